// File: doc/BRIEF.md
# Rational Ratio Clock Synthesizer

This block derives an audio-rate clock from a fast reference clock that has no integer relation to it. An exact remainder accumulator adds a programmable step every reference cycle and subtracts a programmable modulus whenever the sum reaches it. Each wrap closes one output period. The long-run output rate is therefore exactly `reference * step / modulus`, with no accumulated drift. Every output edge falls on a reference edge, so the length of any single period is one of two adjacent whole numbers of reference cycles.

With a 148.5 MHz reference, step 1024 and modulus 12375 give an average of 12.288 MHz, suitable as a converter master clock. Step 256 with the same modulus gives 3.072 MHz, a bit clock for a 48 kHz frame of 64 bits. Alongside the clock the block gives a one-cycle marker for each rising edge and the measured length of the last finished period. These are plain control and status pins: there is no streaming data path, so no valid/ready handshake and no back-pressure. Any cleanup of the clock by an external loop is outside this block.

Top module: `ratclk_synth`

## Requirements
- R1: While `rst_i` is high at a reference edge, `synth_clk_o`, `rise_o` and `per_len_o` are 0, the accumulator is cleared to 0, and step and modulus are captured from the inputs. The first period starts on the first enabled edge after reset.
- R2: With step I below modulus M, each output period lasts either floor(M/I) or floor(M/I)+1 reference cycles.
- R3: Over M enabled reference cycles from reset, exactly I output periods begin. The accumulator is then back at 0, so a new period begins on the next enabled cycle and the period pattern repeats.
- R4: Within each period, `synth_clk_o` is high for the first H = floor(floor(M/I)/2) cycles and low for the rest. The extra cycle of a long period falls in the low phase.
- R5: `rise_o` is high for exactly the one reference cycle in which `synth_clk_o` goes from 0 to 1, and at no other time.
- R6: `per_len_o` changes only together with `rise_o`. It then gives the length in reference cycles of the period that just ended, and it stays 0 until the first period has ended.
- R7: Step and modulus are sampled only on the first cycle of a period. A change in the middle of a period leaves that period's length and high time unaffected.
- R8: While `en_i` is low, `synth_clk_o` and `rise_o` are 0, and the accumulator, position and `per_len_o` hold. Re-enabling resumes the interrupted period where it stopped.
- R9: With step 256 and modulus 12375, periods are 48 or 49 cycles long, with a 24-cycle high phase, and exactly 256 periods begin in 12375 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Fast reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; low freezes the synthesizer |
| inc_i | input | ACC_W | Phase step added each cycle (must be below mod_i) |
| mod_i | input | ACC_W | Modulus of the remainder accumulator |
| synth_clk_o | output | 1 | Synthesized clock |
| rise_o | output | 1 | One-cycle marker on each synthesized rising edge |
| per_len_o | output | CNT_W | Length of the last completed period, in reference cycles |

## Verification
The bench sweeps a full accumulator cycle, 12375 enabled cycles, at both the master-clock and bit-clock ratios, and compares every output on every cycle against an arithmetic model. A remainder that leaks or is dropped at the wrap would give a period count other than I over M cycles, and would not start a fresh period on the cycle after the sweep. An off-by-one in the period counter shows up as lengths of 11/12 or 13/14, or as a high phase of 5 or 7 cycles. Applying a step change mid-period would shorten the current period. A freeze that lets the accumulator drift, or leaves the clock high, would misplace every later edge against the model.

// File: rtl/ratclk_pkg.sv
package ratclk_pkg;

  // High-phase length: half of the nominal (short) period, rounded down.
  function automatic int unsigned half_ratio(int unsigned step, int unsigned modulus);
    if (step == 0) return 0;
    return (modulus / step) >> 1;
  endfunction

endpackage

// File: rtl/ratclk_cfg.sv
module ratclk_cfg
  import ratclk_pkg::*;
#(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_ref_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             begin_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] mod_i,
  output logic [ACC_W-1:0] inc_o,
  output logic [ACC_W-1:0] mod_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [ACC_W-1:0] mod_q_o
);

  logic [ACC_W-1:0] inc_q, mod_q;
  logic [CNT_W-1:0] hi_q, hi_new;

  assign hi_new = CNT_W'(half_ratio(32'(inc_i), 32'(mod_i)));

  // A new period sees the incoming values; otherwise the captured set.
  always_comb begin
    if (begin_i) begin
      inc_o = inc_i;
      mod_o = mod_i;
      hi_o  = hi_new;
    end else begin
      inc_o = inc_q;
      mod_o = mod_q;
      hi_o  = hi_q;
    end
  end

  always_ff @(posedge clk_ref_i) begin
    if (rst_i || (en_i && begin_i)) begin
      inc_q <= inc_i;
      mod_q <= mod_i;
      hi_q  <= hi_new;
    end
  end

  assign mod_q_o = mod_q;

endmodule

// File: rtl/ratclk_acc.sv
module ratclk_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_ref_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] mod_i,
  output logic             begin_o,
  output logic [ACC_W-1:0] acc_o
);

  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic             start_q, wrap_q;
  logic [SUM_W-1:0] sum;
  logic             wrap;

  assign sum  = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap = sum >= {1'b0, mod_i};

  always_ff @(posedge clk_ref_i) begin
    if (rst_i) begin
      acc_q   <= '0;
      start_q <= 1'b1;
      wrap_q  <= 1'b0;
    end else if (en_i) begin
      acc_q   <= wrap ? ACC_W'(sum - {1'b0, mod_i}) : ACC_W'(sum);
      wrap_q  <= wrap;
      start_q <= 1'b0;
    end
  end

  // The cycle after a wrap (or the first cycle after reset) opens a period.
  assign begin_o = start_q | wrap_q;
  assign acc_o   = acc_q;

endmodule

// File: rtl/ratclk_wave.sv
module ratclk_wave #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_ref_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             begin_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             clk_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] len_o
);

  logic [CNT_W-1:0] pos_q, pos_nxt;
  logic             seen_q;

  assign pos_nxt = begin_i ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk_ref_i) begin
    if (rst_i) begin
      pos_q  <= '0;
      seen_q <= 1'b0;
      clk_o  <= 1'b0;
      rise_o <= 1'b0;
      len_o  <= '0;
    end else if (en_i) begin
      pos_q  <= pos_nxt;
      clk_o  <= pos_nxt < hi_i;
      rise_o <= begin_i;
      if (begin_i) begin
        seen_q <= 1'b1;
        if (seen_q) len_o <= pos_q + 1'b1;
      end
    end else begin
      clk_o  <= 1'b0;
      rise_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ratclk_synth.sv
module ratclk_synth #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_ref_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] mod_i,
  output logic             synth_clk_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] per_len_o
);

  logic             period_begin;
  logic [ACC_W-1:0] inc_eff, mod_eff, mod_cur, acc_val;
  logic [CNT_W-1:0] hi_eff;

  ratclk_cfg #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_cfg (
    .clk_ref_i(clk_ref_i), .rst_i(rst_i), .en_i(en_i), .begin_i(period_begin),
    .inc_i(inc_i), .mod_i(mod_i), .inc_o(inc_eff), .mod_o(mod_eff),
    .hi_o(hi_eff), .mod_q_o(mod_cur)
  );

  ratclk_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_ref_i(clk_ref_i), .rst_i(rst_i), .en_i(en_i),
    .inc_i(inc_eff), .mod_i(mod_eff), .begin_o(period_begin), .acc_o(acc_val)
  );

  ratclk_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_ref_i(clk_ref_i), .rst_i(rst_i), .en_i(en_i), .begin_i(period_begin),
    .hi_i(hi_eff), .clk_o(synth_clk_o), .rise_o(rise_o), .len_o(per_len_o)
  );

endmodule

// File: rtl/ratclk_chk.sv
module ratclk_chk #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_ref_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             synth_clk_o,
  input logic             rise_o,
  input logic [CNT_W-1:0] per_len_o,
  input logic [ACC_W-1:0] acc_val,
  input logic [ACC_W-1:0] mod_cur
);

  AST_RISE_IS_HIGH: assert property (@(posedge clk_ref_i) disable iff (rst_i)
    rise_o |-> synth_clk_o); // R5

  AST_RISE_FROM_LOW: assert property (@(posedge clk_ref_i) disable iff (rst_i)
    rise_o |-> !$past(synth_clk_o)); // R5

  AST_LEN_HOLDS: assert property (@(posedge clk_ref_i) disable iff (rst_i)
    !rise_o |-> $stable(per_len_o)); // R6

  AST_IDLE_LOW: assert property (@(posedge clk_ref_i) disable iff (rst_i)
    !en_i |=> (!synth_clk_o && !rise_o)); // R8

  AST_ACC_IN_RANGE: assert property (@(posedge clk_ref_i) disable iff (rst_i)
    acc_val < mod_cur); // R3

endmodule

bind ratclk_synth ratclk_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk_ref_i(clk_ref_i), .rst_i(rst_i), .en_i(en_i), .synth_clk_o(synth_clk_o),
  .rise_o(rise_o), .per_len_o(per_len_o), .acc_val(acc_val), .mod_cur(mod_cur)
);

// File: tb/test_ratclk_synth.sv
`timescale 1ns/1ps
module test_ratclk_synth;
  localparam int ACC_W = 16;
  localparam int CNT_W = 8;

  logic clk_ref_i = 1'b0;
  logic rst_i = 1'b1, en_i = 1'b0;
  logic [ACC_W-1:0] inc_i = 16'd1024, mod_i = 16'd12375;
  logic synth_clk_o, rise_o;
  logic [CNT_W-1:0] per_len_o;

  always #4 clk_ref_i = ~clk_ref_i;

  ratclk_synth #(.ACC_W(ACC_W), .CNT_W(CNT_W)) i_ratclk_synth (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  // Arithmetic model of the requirements
  int m_acc, m_pos, m_inc, m_mod, m_hi, m_len;
  bit m_start, m_wrap, m_clk, m_rise;
  // Sweep statistics from observed outputs
  int rises, hcnt, bad_len, bad_hi;
  int lo_len, exp_hi;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model();
    if (rst_i) begin
      m_acc = 0; m_pos = 0; m_start = 1; m_wrap = 0; m_len = 0;
      m_inc = inc_i; m_mod = mod_i; m_hi = (mod_i / inc_i) / 2;
      m_clk = 0; m_rise = 0;
    end else if (en_i) begin
      m_rise = m_start | m_wrap;
      if (m_rise) begin
        if (!m_start) m_len = m_pos + 1;
        m_inc = inc_i; m_mod = mod_i; m_hi = (mod_i / inc_i) / 2;
        m_pos = 0;
      end else m_pos++;
      m_acc = m_acc + m_inc;
      m_wrap = m_acc >= m_mod;
      if (m_wrap) m_acc -= m_mod;
      m_start = 0;
      m_clk = m_pos < m_hi;
    end else begin
      m_clk = 0; m_rise = 0;
    end
  endtask

  task automatic tick();
    @(posedge clk_ref_i);
    model();
    @(negedge clk_ref_i);
    chk(synth_clk_o == m_clk, "R4 clock level", synth_clk_o, m_clk);
    chk(rise_o == m_rise, "R5 rise marker", rise_o, m_rise);
    chk(per_len_o == m_len, "R6 period length", per_len_o, m_len);
    if (rise_o) begin
      if (rises > 0) begin
        if (per_len_o != lo_len && per_len_o != lo_len + 1) bad_len++;
        if (hcnt != exp_hi) bad_hi++;
      end
      rises++;
      hcnt = 0;
    end
    if (synth_clk_o) hcnt++;
  endtask

  task automatic do_reset(int step, int modulus);
    rst_i = 1; en_i = 0; inc_i = 16'(step); mod_i = 16'(modulus);
    tick(); tick();
    chk(synth_clk_o == 0 && rise_o == 0, "R1 outputs low in reset", synth_clk_o, 0);
    chk(per_len_o == 0, "R1 length zero in reset", per_len_o, 0);
    rst_i = 0;
    rises = 0; hcnt = 0; bad_len = 0; bad_hi = 0;
  endtask

  initial begin
    // R1: reset, then idle with enable low
    do_reset(1024, 12375);
    tick();
    chk(synth_clk_o == 0, "R1 idle after reset", synth_clk_o, 0);

    // R2 R3 R4: full accumulator cycle, master-clock ratio
    lo_len = 12; exp_hi = 6;
    en_i = 1;
    for (int i = 0; i < 12375; i++) tick();
    chk(rises == 1024, "R3 periods in 12375 cycles", rises, 1024);
    chk(bad_len == 0, "R2 lengths 12 or 13", bad_len, 0);
    chk(bad_hi == 0, "R4 high phase 6", bad_hi, 0);
    tick();
    chk(rise_o == 1, "R3 accumulator back at zero", rise_o, 1);
    for (int i = 0; i < 13; i++) tick();
    chk(rise_o == 1 && per_len_o == 13, "R3 pattern repeats", per_len_o, 13);

    // R8: freeze in mid-period (3 cycles into a period, so the clock is high)
    for (int i = 0; i < 3; i++) tick();
    begin
      automatic int held = per_len_o;
      chk(synth_clk_o == 1, "R8 clock high before freeze", synth_clk_o, 1);
      en_i = 0;
      for (int i = 0; i < 6; i++) begin
        tick();
        chk(synth_clk_o == 0 && rise_o == 0, "R8 clock low while idle", synth_clk_o, 0);
        chk(per_len_o == held, "R8 length held", per_len_o, held);
      end
      en_i = 1;
    end
    for (int i = 0; i < 40; i++) tick();

    // R7: change step mid-period; the running period keeps the old ratio
    while (!(synth_clk_o && !rise_o)) tick();
    inc_i = 16'd2048;
    while (!rise_o) tick();
    chk(per_len_o == 12 || per_len_o == 13, "R7 running period unchanged", per_len_o, 12);
    tick();
    while (!rise_o) tick();
    chk(per_len_o == 6 || per_len_o == 7, "R7 new ratio after boundary", per_len_o, 6);

    // R9: bit-clock ratio sweep
    do_reset(256, 12375);
    lo_len = 48; exp_hi = 24;
    en_i = 1;
    for (int i = 0; i < 12375; i++) tick();
    chk(rises == 256, "R9 periods in 12375 cycles", rises, 256);
    chk(bad_len == 0, "R9 lengths 48 or 49", bad_len, 0);
    chk(bad_hi == 0, "R9 high phase 24", bad_hi, 0);
    tick();
    chk(rise_o == 1, "R9 accumulator back at zero", rise_o, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule